// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host a narrow window onto a wider internal register space. The host sees a handful of 8-byte registers. It first loads a target address into the pointer register. Each later access to the window register is then turned into one transaction on a request/acknowledge target port at that address. A read of the window returns the target's 64-bit value, and a write of the window sends the host's value to the target. The window register stores nothing itself.

Next to the pointer and the window, the bank has a sticky status register and two control registers. The status bits are cleared by writing ones to them. The control registers take any write quietly and change nothing. A write to an unmapped index, or an access that is not 8 bytes wide and 8-byte aligned, is refused with an error response. While a target transaction is pending, the host access is held off through the ready signal. Only one transaction is ever outstanding.

Top module: `ira_bridge`

## Requirements
- R1: A write to the pointer register (byte address 0x00) stores bits [11:0] of the written value and drops the rest. A read of it returns those 12 bits zero-extended to 64 bits.
- R2: A read of the window register (byte address 0x08) issues one target read (`tgt_we`=0) at the stored pointer. The host access completes in the cycle the target acknowledges, and returns `tgt_rdata`.
- R3: A write of the window register issues one target write (`tgt_we`=1) at the stored pointer, carrying the full 64-bit host value.
- R4: While a target transaction is pending, `hst_ready` stays low, and `tgt_req`, `tgt_addr`, `tgt_we` and `tgt_wdata` stay stable until `tgt_ack`. The request drops in the cycle after the acknowledge. A window access with an acknowledge delay of d cycles completes d+1 cycles after it is presented.
- R5: A write to the status register (byte address 0x10) clears every status bit that is 1 in the written value and leaves the other bits unchanged. Bit 0 is the target-error flag and bit 1 is the bad-access flag.
- R6: The control registers (byte addresses 0x18 and 0x20) accept writes with no error and no change of state. They read as zero.
- R7: A write to any index above 4 (byte address 0x28 and up) returns an error, changes no register, and sets status bit 1.
- R8: An access whose size is not 8 bytes, or whose address bits [2:0] are not zero, returns an error, starts no target transaction, changes no register, and sets status bit 1.
- R9: A target acknowledge with `tgt_err` high completes the host access with `hst_err` high and sets status bit 0. That bit stays set until it is cleared by a write of one.
- R10: After reset the pointer and the status register are zero, `tgt_req` is low, and `hst_ready` is low while `hst_valid` is low.
- R11: A read of an unmapped index returns zero without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hst_valid | input | 1 | Host access request, held until ready |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 8 | Host byte address; register index is bits [7:3] |
| hst_size | input | 4 | Access size in bytes; only 8 is legal |
| hst_wdata | input | 64 | Host write data |
| hst_ready | output | 1 | Access completes in this cycle |
| hst_rdata | output | 64 | Read data, valid with hst_ready |
| hst_err | output | 1 | Error response, valid with hst_ready |
| tgt_req | output | 1 | Target transaction pending |
| tgt_we | output | 1 | Target transaction is a write |
| tgt_addr | output | 12 | Target register address (the pointer) |
| tgt_wdata | output | 64 | Target write data |
| tgt_ack | input | 1 | Target completes the pending transaction |
| tgt_rdata | input | 64 | Target read data, valid with tgt_ack |
| tgt_err | input | 1 | Target error response, valid with tgt_ack |

## Verification
The assertions assume that the target raises `tgt_ack` only while `tgt_req` is high. They also assume that the host keeps `hst_valid`, `hst_write`, `hst_addr`, `hst_size` and `hst_wdata` unchanged from the moment it raises a request until the cycle in which `hst_ready` is seen. The bench's target model acknowledges only a pending request, after a programmed delay, and drops the acknowledge on the next cycle. Its host task drives one access at a time and holds every field until the completing edge has passed.

// File: rtl/ira_pkg.sv
package ira_pkg;

    // register indices (byte address >> 3)
    localparam int IDX_PTR  = 0;
    localparam int IDX_WIN  = 1;
    localparam int IDX_STAT = 2;
    localparam int IDX_CTLA = 3;
    localparam int IDX_CTLB = 4;

    // status bit positions
    localparam int STAT_TERR = 0;
    localparam int STAT_BAD  = 1;

    localparam int ACC_BYTES = 8;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic ptr;
        logic win;
        logic stat;
        logic ctl;
        logic unk;
    } sel_t;

endpackage

// File: rtl/ira_decode.sv
module ira_decode
    import ira_pkg::*;
#(
    parameter int HAW = 8
) (
    input  logic [HAW-1:0] addr,
    input  logic [3:0]     size,
    output sel_t           sel,
    output logic           acc_ok
);
    localparam int IW = HAW - 3;

    logic [IW-1:0] idx;
    assign idx = addr[HAW-1:3];

    always_comb begin
        sel = '0;
        case (idx)
            IW'(IDX_PTR):  sel.ptr  = 1'b1;
            IW'(IDX_WIN):  sel.win  = 1'b1;
            IW'(IDX_STAT): sel.stat = 1'b1;
            IW'(IDX_CTLA): sel.ctl  = 1'b1;
            IW'(IDX_CTLB): sel.ctl  = 1'b1;
            default:       sel.unk  = 1'b1;
        endcase
    end

    assign acc_ok = (size == 4'(ACC_BYTES)) && (addr[2:0] == 3'b000);

endmodule

// File: rtl/ira_regbank.sv
module ira_regbank #(
    parameter int TAW = 12,
    parameter int STW = 2
) (
    input  logic           clk,
    input  logic           rst_ni,
    input  logic           ptr_we,
    input  logic [TAW-1:0] ptr_val,
    input  logic           stat_clr_we,
    input  logic [STW-1:0] stat_clr_mask,
    input  logic [STW-1:0] stat_set,
    output logic [TAW-1:0] ptr_q,
    output logic [STW-1:0] stat_q
);
    typedef struct packed {
        logic [TAW-1:0] ptr;
        logic [STW-1:0] stat;
    } rb_t;

    rb_t rb_d, rb_q;

    always_comb begin
        rb_d = rb_q;
        if (ptr_we) begin
            rb_d.ptr = ptr_val;
        end
        if (stat_clr_we) begin
            rb_d.stat = rb_d.stat & ~stat_clr_mask;
        end
        // a new event in the same cycle wins over the clear
        rb_d.stat = rb_d.stat | stat_set;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            rb_q <= '0;
        end else begin
            rb_q <= rb_d;
        end
    end

    assign ptr_q  = rb_q.ptr;
    assign stat_q = rb_q.stat;

endmodule

// File: rtl/ira_seq.sv
module ira_seq
    import ira_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_ni,
    input  logic          start,
    input  logic          start_we,
    input  logic [DW-1:0] start_wdata,
    input  logic          tgt_ack,
    output logic          busy,
    output logic          tgt_we,
    output logic [DW-1:0] tgt_wdata
);
    typedef struct packed {
        seq_state_e    st;
        logic          we;
        logic [DW-1:0] wd;
    } sq_t;

    sq_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        case (sq_q.st)
            SEQ_IDLE: begin
                if (start) begin
                    sq_d.st = SEQ_WAIT;
                    sq_d.we = start_we;
                    sq_d.wd = start_wdata;
                end
            end
            SEQ_WAIT: begin
                if (tgt_ack) begin
                    sq_d.st = SEQ_IDLE;
                end
            end
            default: sq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            sq_q <= '{st: SEQ_IDLE, we: 1'b0, wd: '0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy      = (sq_q.st == SEQ_WAIT);
    assign tgt_we    = sq_q.we;
    assign tgt_wdata = sq_q.wd;

endmodule

// File: rtl/ira_bridge.sv
module ira_bridge
    import ira_pkg::*;
#(
    parameter int HOST_AW = 8,
    parameter int TGT_AW  = 12,
    parameter int DATA_W  = 64,
    parameter int STAT_W  = 2
) (
    input  logic               clk,
    input  logic               rst_ni,
    input  logic               hst_valid,
    input  logic               hst_write,
    input  logic [HOST_AW-1:0] hst_addr,
    input  logic [3:0]         hst_size,
    input  logic [DATA_W-1:0]  hst_wdata,
    output logic               hst_ready,
    output logic [DATA_W-1:0]  hst_rdata,
    output logic               hst_err,
    output logic               tgt_req,
    output logic               tgt_we,
    output logic [TGT_AW-1:0]  tgt_addr,
    output logic [DATA_W-1:0]  tgt_wdata,
    input  logic               tgt_ack,
    input  logic [DATA_W-1:0]  tgt_rdata,
    input  logic               tgt_err
);
    sel_t              sel;
    logic              acc_ok;
    logic              busy;
    logic              start;
    logic              local_go;
    logic              local_wr;
    logic              bad;
    logic [STAT_W-1:0] stat_set;
    logic [STAT_W-1:0] stat_q;
    logic [TGT_AW-1:0] ptr_q;
    logic [DATA_W-1:0] local_rdata;

    ira_decode #(.HAW(HOST_AW)) u_dec (
        .addr   (hst_addr),
        .size   (hst_size),
        .sel    (sel),
        .acc_ok (acc_ok)
    );

    always_comb begin
        start    = hst_valid && !busy && acc_ok && sel.win;
        local_go = hst_valid && !busy && !start;
        local_wr = local_go && acc_ok && hst_write;
        bad      = !acc_ok || (hst_write && sel.unk);

        stat_set            = '0;
        stat_set[STAT_TERR] = busy && tgt_ack && tgt_err;
        stat_set[STAT_BAD]  = local_go && bad;

        local_rdata = '0;
        if (acc_ok && sel.ptr) begin
            local_rdata = DATA_W'(ptr_q);
        end else if (acc_ok && sel.stat) begin
            local_rdata = DATA_W'(stat_q);
        end

        if (busy) begin
            hst_ready = tgt_ack;
            hst_err   = tgt_ack && tgt_err;
            hst_rdata = tgt_rdata;
        end else begin
            hst_ready = local_go;
            hst_err   = local_go && bad;
            hst_rdata = local_rdata;
        end
    end

    ira_regbank #(.TAW(TGT_AW), .STW(STAT_W)) u_rb (
        .clk           (clk),
        .rst_ni        (rst_ni),
        .ptr_we        (local_wr && sel.ptr),
        .ptr_val       (hst_wdata[TGT_AW-1:0]),
        .stat_clr_we   (local_wr && sel.stat),
        .stat_clr_mask (hst_wdata[STAT_W-1:0]),
        .stat_set      (stat_set),
        .ptr_q         (ptr_q),
        .stat_q        (stat_q)
    );

    ira_seq #(.DW(DATA_W)) u_seq (
        .clk         (clk),
        .rst_ni      (rst_ni),
        .start       (start),
        .start_we    (hst_write),
        .start_wdata (hst_wdata),
        .tgt_ack     (tgt_ack),
        .busy        (busy),
        .tgt_we      (tgt_we),
        .tgt_wdata   (tgt_wdata)
    );

    assign tgt_req  = busy;
    assign tgt_addr = ptr_q;

endmodule

// File: rtl/ira_checker.sv
module ira_checker #(
    parameter int HAW = 8,
    parameter int TAW = 12,
    parameter int DW  = 64,
    parameter int STW = 2
) (
    input logic           clk,
    input logic           rst_ni,
    input logic           hst_valid,
    input logic           hst_write,
    input logic [HAW-1:0] hst_addr,
    input logic [3:0]     hst_size,
    input logic [DW-1:0]  hst_wdata,
    input logic           hst_ready,
    input logic           hst_err,
    input logic           tgt_req,
    input logic           tgt_we,
    input logic [TAW-1:0] tgt_addr,
    input logic [DW-1:0]  tgt_wdata,
    input logic           tgt_ack,
    input logic           tgt_err,
    input logic [STW-1:0] stat
);
    logic [HAW-4:0] idx;
    logic           fire;
    logic           legal;
    assign idx   = hst_addr[HAW-1:3];
    assign fire  = hst_valid && hst_ready;
    assign legal = (hst_size == 4'd8) && (hst_addr[2:0] == 3'b000);

    AST_PEND_STALL: assert property (@(posedge clk) disable iff (!rst_ni)
        tgt_req && !tgt_ack |-> !hst_ready) else $error("pending stall"); // R4

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
        tgt_req && !tgt_ack |=> tgt_req && $stable(tgt_addr) && $stable(tgt_we)
                               && $stable(tgt_wdata)) else $error("req hold"); // R4

    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_ni)
        tgt_req && tgt_ack |=> !tgt_req) else $error("req release"); // R4

    AST_ACK_DONE: assert property (@(posedge clk) disable iff (!rst_ni)
        tgt_req && tgt_ack |-> hst_ready && (hst_err == tgt_err)) else $error("ack done"); // R2

    AST_WIN_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
        !tgt_req && hst_valid && hst_write && legal && idx == 1
        |=> tgt_req && tgt_we && tgt_wdata == $past(hst_wdata)) else $error("win write"); // R3

    AST_TERR_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
        tgt_req && tgt_ack && tgt_err |=> stat[0]) else $error("terr sticky"); // R9

    AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_ni)
        fire && !legal |-> hst_err && !tgt_req) else $error("bad size"); // R8

    AST_BAD_SIZE_NOREQ: assert property (@(posedge clk) disable iff (!rst_ni)
        fire && !legal |=> !tgt_req && stat[1]) else $error("bad size noreq"); // R8

    AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (!rst_ni)
        fire && hst_write && idx > 4 |-> hst_err) else $error("unmapped write"); // R7

    AST_PTR_DROP: assert property (@(posedge clk) disable iff (!rst_ni)
        fire && hst_write && legal && idx == 0
        |=> tgt_addr == $past(hst_wdata[TAW-1:0])) else $error("ptr drop"); // R1

    AST_CTRL_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
        fire && legal && (idx == 3 || idx == 4) |-> !hst_err) else $error("ctrl quiet"); // R6

endmodule

bind ira_bridge ira_checker #(
    .HAW (HOST_AW),
    .TAW (TGT_AW),
    .DW  (DATA_W),
    .STW (STAT_W)
) u_chk (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .hst_valid (hst_valid),
    .hst_write (hst_write),
    .hst_addr  (hst_addr),
    .hst_size  (hst_size),
    .hst_wdata (hst_wdata),
    .hst_ready (hst_ready),
    .hst_err   (hst_err),
    .tgt_req   (tgt_req),
    .tgt_we    (tgt_we),
    .tgt_addr  (tgt_addr),
    .tgt_wdata (tgt_wdata),
    .tgt_ack   (tgt_ack),
    .tgt_err   (tgt_err),
    .stat      (stat_q)
);

// File: tb/tb_ira_bridge.sv
module tb_ira_bridge;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        hv = 1'b0;
    logic        hw = 1'b0;
    logic [7:0]  ha = '0;
    logic [3:0]  hs = 4'd8;
    logic [63:0] hd = '0;
    logic        hst_ready;
    logic [63:0] hst_rdata;
    logic        hst_err;
    logic        tgt_req;
    logic        tgt_we;
    logic [11:0] tgt_addr;
    logic [63:0] tgt_wdata;
    logic        tm_ack = 1'b0;
    logic [63:0] tm_rd = '0;
    logic        tm_terr = 1'b0;

    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    ira_bridge dut (
        .clk       (clk),
        .rst_ni    (rst_ni),
        .hst_valid (hv),
        .hst_write (hw),
        .hst_addr  (ha),
        .hst_size  (hs),
        .hst_wdata (hd),
        .hst_ready (hst_ready),
        .hst_rdata (hst_rdata),
        .hst_err   (hst_err),
        .tgt_req   (tgt_req),
        .tgt_we    (tgt_we),
        .tgt_addr  (tgt_addr),
        .tgt_wdata (tgt_wdata),
        .tgt_ack   (tm_ack),
        .tgt_rdata (tm_rd),
        .tgt_err   (tm_terr)
    );

    // target model: acknowledge a pending request after tm_delay cycles
    int          tm_delay = 0;
    int          tm_cnt = 0;
    int          tm_n = 0;
    logic        tm_we_seen = 1'b0;
    logic [11:0] tm_addr_seen = '0;
    logic [63:0] tm_wd_seen = '0;

    always @(negedge clk) begin
        if (tm_ack) begin
            tm_ack = 1'b0;
            tm_cnt = 0;
        end else if (tgt_req) begin
            if (tm_cnt >= tm_delay) begin
                tm_ack       = 1'b1;
                tm_n         = tm_n + 1;
                tm_we_seen   = tgt_we;
                tm_addr_seen = tgt_addr;
                tm_wd_seen   = tgt_wdata;
            end else begin
                tm_cnt = tm_cnt + 1;
            end
        end
    end

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic host_acc(input logic w, input logic [7:0] a, input logic [3:0] sz,
                            input logic [63:0] wd, output logic [63:0] rd,
                            output logic e, output int cyc);
        @(negedge clk);
        hv = 1'b1; hw = w; ha = a; hs = sz; hd = wd;
        cyc = 0;
        #1;
        while (!hst_ready && cyc < 500) begin
            @(negedge clk);
            #1;
            cyc++;
        end
        rd = hst_rdata;
        e  = hst_err;
        @(posedge clk);
        #1;
        hv = 1'b0;
    endtask

    typedef struct packed {
        logic        w;
        logic [7:0]  a;
        logic [3:0]  sz;
        logic [63:0] wd;
        logic [3:0]  dly;
        logic        terr;
        logic [63:0] trd;
        logic [63:0] erd;
        logic        eerr;
        logic        etxn;
        logic [11:0] etaddr;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 8'h00, 4'd8, 64'hFFFF_FFFF_FFFF_FABC, 4'd0, 1'b0, 64'h0, 64'h0, 1'b0, 1'b0, 12'h000, 8'd1},              // R1
        '{1'b0, 8'h00, 4'd8, 64'h0, 4'd0, 1'b0, 64'h0, 64'h0ABC, 1'b0, 1'b0, 12'h000, 8'd1},                             // R1
        '{1'b0, 8'h08, 4'd8, 64'h0, 4'd2, 1'b0, 64'h1122_3344_5566_7788, 64'h1122_3344_5566_7788, 1'b0, 1'b1, 12'hABC, 8'd2}, // R2
        '{1'b1, 8'h08, 4'd8, 64'hDEAD_BEEF_CAFE_F00D, 4'd0, 1'b0, 64'h0, 64'h0, 1'b0, 1'b1, 12'hABC, 8'd3},              // R3
        '{1'b1, 8'h18, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 4'd0, 1'b0, 64'h0, 64'h0, 1'b0, 1'b0, 12'h000, 8'd6},              // R6
        '{1'b1, 8'h20, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 4'd0, 1'b0, 64'h0, 64'h0, 1'b0, 1'b0, 12'h000, 8'd6},              // R6
        '{1'b0, 8'h20, 4'd8, 64'h0, 4'd0, 1'b0, 64'h0, 64'h0, 1'b0, 1'b0, 12'h000, 8'd6},                                // R6
        '{1'b0, 8'h00, 4'd8, 64'h0, 4'd0, 1'b0, 64'h0, 64'h0ABC, 1'b0, 1'b0, 12'h000, 8'd6},                             // R6
        '{1'b1, 8'h00, 4'd8, 64'h5123, 4'd0, 1'b0, 64'h0, 64'h0, 1'b0, 1'b0, 12'h000, 8'd1},                             // R1
        '{1'b0, 8'h08, 4'd8, 64'h0, 4'd3, 1'b1, 64'h0, 64'h0, 1'b1, 1'b1, 12'h123, 8'd9},                                // R9
        '{1'b0, 8'h10, 4'd8, 64'h0, 4'd0, 1'b0, 64'h0, 64'h1, 1'b0, 1'b0, 12'h000, 8'd9},                                // R9
        '{1'b1, 8'h10, 4'd8, 64'h2, 4'd0, 1'b0, 64'h0, 64'h0, 1'b0, 1'b0, 12'h000, 8'd5},                                // R5
        '{1'b0, 8'h10, 4'd8, 64'h0, 4'd0, 1'b0, 64'h0, 64'h1, 1'b0, 1'b0, 12'h000, 8'd5},                                // R5
        '{1'b1, 8'h10, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 4'd0, 1'b0, 64'h0, 64'h0, 1'b0, 1'b0, 12'h000, 8'd5},              // R5
        '{1'b0, 8'h10, 4'd8, 64'h0, 4'd0, 1'b0, 64'h0, 64'h0, 1'b0, 1'b0, 12'h000, 8'd5},                                // R5
        '{1'b1, 8'h28, 4'd8, 64'h77, 4'd0, 1'b0, 64'h0, 64'h0, 1'b1, 1'b0, 12'h000, 8'd7},                               // R7
        '{1'b0, 8'h10, 4'd8, 64'h0, 4'd0, 1'b0, 64'h0, 64'h2, 1'b0, 1'b0, 12'h000, 8'd7},                                // R7
        '{1'b0, 8'h00, 4'd8, 64'h0, 4'd0, 1'b0, 64'h0, 64'h0123, 1'b0, 1'b0, 12'h000, 8'd7},                             // R7
        '{1'b0, 8'h30, 4'd8, 64'h0, 4'd0, 1'b0, 64'h0, 64'h0, 1'b0, 1'b0, 12'h000, 8'd11},                               // R11
        '{1'b1, 8'h10, 4'd8, 64'h2, 4'd0, 1'b0, 64'h0, 64'h0, 1'b0, 1'b0, 12'h000, 8'd5},                                // R5
        '{1'b0, 8'h10, 4'd8, 64'h0, 4'd0, 1'b0, 64'h0, 64'h0, 1'b0, 1'b0, 12'h000, 8'd5},                                // R5
        '{1'b1, 8'h08, 4'd8, 64'h0000_0000_0000_0077, 4'd1, 1'b0, 64'h0, 64'h0, 1'b0, 1'b1, 12'h123, 8'd3}               // R3
    };

    initial begin
        logic [63:0] rd;
        logic        e;
        int          cyc;
        int          n0;

        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        chk("R10 tgt_req after reset", 64'(tgt_req), 64'd0);
        chk("R10 hst_ready idle", 64'(hst_ready), 64'd0);
        rst_ni = 1'b1;
        host_acc(1'b0, 8'h00, 4'd8, 64'h0, rd, e, cyc);
        chk("R10 pointer reset value", rd, 64'h0);
        host_acc(1'b0, 8'h10, 4'd8, 64'h0, rd, e, cyc);
        chk("R10 status reset value", rd, 64'h0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec %0d", TBL[i].rq, i);
            tm_delay = int'(TBL[i].dly);
            tm_terr  = TBL[i].terr;
            tm_rd    = TBL[i].trd;
            n0 = tm_n;
            host_acc(TBL[i].w, TBL[i].a, TBL[i].sz, TBL[i].wd, rd, e, cyc);
            chk({tag, " err"}, 64'(e), 64'(TBL[i].eerr));
            if (!TBL[i].w && !TBL[i].eerr) chk({tag, " rdata"}, rd, TBL[i].erd);
            chk({tag, " txn count"}, 64'(tm_n - n0), TBL[i].etxn ? 64'd1 : 64'd0);
            if (TBL[i].etxn) begin
                chk({tag, " target addr"}, 64'(tm_addr_seen), 64'(TBL[i].etaddr));
                chk({tag, " target we"}, 64'(tm_we_seen), 64'(TBL[i].w));
                if (TBL[i].w) chk({tag, " target wdata"}, tm_wd_seen, TBL[i].wd);
            end
        end
        tm_terr = 1'b0;

        // R4: stall length and single transaction
        tm_delay = 6;
        tm_rd = 64'hA5A5_0000_FFFF_1234;
        n0 = tm_n;
        host_acc(1'b0, 8'h08, 4'd8, 64'h0, rd, e, cyc);
        chk("R4 stall cycles", 64'(cyc), 64'd7);
        chk("R4 one transaction", 64'(tm_n - n0), 64'd1);
        chk("R2 long read data", rd, 64'hA5A5_0000_FFFF_1234);
        #1;
        chk("R4 request released", 64'(tgt_req), 64'd0);

        // R8: bad size on window, no transaction
        tm_delay = 0;
        n0 = tm_n;
        host_acc(1'b0, 8'h08, 4'd4, 64'h0, rd, e, cyc);
        chk("R8 size error", 64'(e), 64'd1);
        chk("R8 no target txn", 64'(tm_n - n0), 64'd0);
        host_acc(1'b0, 8'h10, 4'd8, 64'h0, rd, e, cyc);
        chk("R8 status bad flag", rd, 64'h2);
        // R8: misaligned pointer write is refused
        host_acc(1'b1, 8'h01, 4'd8, 64'h0FFF, rd, e, cyc);
        chk("R8 misaligned error", 64'(e), 64'd1);
        host_acc(1'b0, 8'h00, 4'd8, 64'h0, rd, e, cyc);
        chk("R8 pointer unchanged", rd, 64'h0123);

        // R5 / R9: both bits set, clear only bit 0
        tm_terr = 1'b1;
        host_acc(1'b1, 8'h08, 4'd8, 64'h1, rd, e, cyc);
        chk("R9 write target error", 64'(e), 64'd1);
        tm_terr = 1'b0;
        host_acc(1'b1, 8'h10, 4'd8, 64'h1, rd, e, cyc);
        host_acc(1'b0, 8'h10, 4'd8, 64'h0, rd, e, cyc);
        chk("R5 partial clear", rd, 64'h2);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule